// File: doc/BRIEF.md
# Two-Phase Diagonal Cell for a Triangular Solver Array

This block is the diagonal element of a triangular systolic array that processes a matrix in two passes. It keeps one stored diagonal value. Each entry that arrives from the row above is combined with that value to make a coefficient pair, which is passed to the right so the rest of the row can be updated.

In the rotation pass, the cell builds plane-rotation coefficients that cancel the incoming entry. It then replaces its stored value with the new vector length. In the elimination pass, the stored value is used as a fixed pivot. The cell emits a Gaussian-elimination multiplier and does not change the stored value.

All values are signed fixed point with 8 fraction bits (Q8.8 at the default 16-bit width). The square root and the divisions are computed bit-serially. The cell accepts one entry at a time, using a busy/done handshake.

Top module: `sysbc_cell`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `err`, `c_out`, `s_out` and `r_out` are all zero.
- R2: A rotation (`phase_sel`=0) with stored value r and entry x, not both zero, stores r' = min(floor(sqrt(r*r + x*x)), 32767) in raw Q8.8 units. The new value appears on `r_out` when `done` is high.
- R3: Every quotient q(n, d) equals the sign of n/d times floor(|n|*256/|d|), saturated to the range -32768..32767. A rotation returns `c_out` = q(r, r') and `s_out` = q(x, r').
- R4: A rotation with r = 0 and x = 0 returns `c_out` = 0x0100 (one), `s_out` = 0, and leaves the stored value at zero.
- R5: An elimination (`phase_sel`=1) with r nonzero returns `c_out` = 0 and `s_out` = -q(x, r), saturated to the range -32768..32767. The stored value is not changed.
- R6: An elimination with r = 0 returns `err`=1, `c_out`=0 and `s_out`=0. Every other completion returns `err`=0.
- R7: `busy` rises in the cycle after `start` is accepted in idle. `done` is high for exactly one cycle, with the results valid on that cycle. `start` is ignored while `busy` is high.
- R8: `clr` in idle sets the stored value to zero, and a `start` in the same cycle is dropped. `clr` is ignored while `busy` is high.
- R9: `c_out`, `s_out` and `err` hold their values while the cell is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clear the stored diagonal value (idle only) |
| start | input | 1 | Entry strobe, sampled while idle |
| phase_sel | input | 1 | 0 = rotation pass, 1 = elimination pass |
| x_in | input | 16 | Incoming entry, signed Q8.8 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| c_out | output | 16 | Cosine-like coefficient, signed Q8.8 |
| s_out | output | 16 | Sine-like coefficient or multiplier, signed Q8.8 |
| err | output | 1 | Zero pivot seen in the elimination pass |
| r_out | output | 16 | Stored diagonal value, signed Q8.8 |

## Verification
The assertions assume two things about the inputs. First, `x_in` and `phase_sel` matter only in the idle cycle where `start` is sampled. Second, the internal divider is never started with a zero divisor, because the control path screens out zero pivots and zero vector lengths first.

The stimulus changes inputs only on falling edges and holds `start` for one cycle. It deliberately raises `start` and `clr` during busy periods, so the ignore rules are exercised without breaking these assumptions.

The sweeps form stored values from extreme, unit and mixed-sign entries, including -32768 and 32767. Each pair of entries is followed by elimination passes on the resulting pivot.

// File: rtl/sysbc_pkg.sv
package sysbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT,
    ST_QC,
    ST_QS,
    ST_FIN
  } bc_state_e;

  typedef enum logic {
    PH_ROTATE = 1'b0,
    PH_ELIM   = 1'b1
  } bc_phase_e;

endpackage

// File: rtl/sysbc_isqrt.sv
// Bit-serial integer square root: one result bit per cycle.
module sysbc_isqrt #(
  parameter int RW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [RW-1:0]   rad,
  output logic            fin,
  output logic [RW/2-1:0] root
);
  localparam int OW = RW / 2;
  localparam int CW = $clog2(OW + 1);

  logic [RW-1:0] rem_q, rem_n, acc_q, acc_n, bit_q, bit_n, trial;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n, fin_q, fin_n, en;

  assign en = go | run_q;

  always_comb begin
    rem_n = rem_q;
    acc_n = acc_q;
    bit_n = bit_q;
    cnt_n = cnt_q;
    run_n = run_q;
    fin_n = 1'b0;
    trial = acc_q + bit_q;
    if (go) begin
      rem_n = rad;
      acc_n = '0;
      bit_n = {2'b01, {(RW-2){1'b0}}};
      cnt_n = CW'(OW);
      run_n = 1'b1;
    end else if (run_q) begin
      if (rem_q >= trial) begin
        rem_n = rem_q - trial;
        acc_n = (acc_q >> 1) + bit_q;
      end else begin
        acc_n = acc_q >> 1;
      end
      bit_n = bit_q >> 2;
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      bit_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_n;
      if (en) begin
        rem_q <= rem_n;
        acc_q <= acc_n;
        bit_q <= bit_n;
        cnt_q <= cnt_n;
        run_q <= run_n;
      end
    end
  end

  assign fin  = fin_q;
  assign root = acc_q[OW-1:0];

  // R2: the remainder left by a floor root never exceeds twice the root
  a_r2_root_floor: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q <= {acc_q[RW-2:0], 1'b0}));

endmodule

// File: rtl/sysbc_div.sv
// Restoring signed fixed-point divider with saturation.
module sysbc_div #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic signed [DW-1:0] num,
  input  logic signed [DW-1:0] den,
  input  logic                 neg,
  output logic                 fin,
  output logic signed [DW-1:0] quo
);
  localparam int QW = DW + FW;
  localparam int CW = $clog2(QW + 1);
  localparam logic [QW-1:0] PMAX = {{(FW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [QW-1:0] NMAG = {{FW{1'b0}}, 1'b1, {(DW-1){1'b0}}};

  logic [QW-1:0] dvd_q, dvd_n;
  logic [DW-1:0] rem_q, rem_n, dm_q, dm_n, nmag, dmag;
  logic [DW:0]   sh, diff;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sgn_q, sgn_n, run_q, run_n, fin_q, fin_n, en;

  assign nmag = num[DW-1] ? (~num + 1'b1) : num;
  assign dmag = den[DW-1] ? (~den + 1'b1) : den;
  assign sh   = {rem_q, dvd_q[QW-1]};
  assign diff = sh - {1'b0, dm_q};
  assign en   = go | run_q;

  always_comb begin
    dvd_n = dvd_q;
    rem_n = rem_q;
    dm_n  = dm_q;
    sgn_n = sgn_q;
    cnt_n = cnt_q;
    run_n = run_q;
    fin_n = 1'b0;
    if (go) begin
      dvd_n = {nmag, {FW{1'b0}}};
      rem_n = '0;
      dm_n  = dmag;
      sgn_n = num[DW-1] ^ den[DW-1] ^ neg;
      cnt_n = CW'(QW);
      run_n = 1'b1;
    end else if (run_q) begin
      if (!diff[DW]) begin
        rem_n = diff[DW-1:0];
        dvd_n = {dvd_q[QW-2:0], 1'b1};
      end else begin
        rem_n = sh[DW-1:0];
        dvd_n = {dvd_q[QW-2:0], 1'b0};
      end
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      rem_q <= '0;
      dm_q  <= '0;
      sgn_q <= 1'b0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_n;
      if (en) begin
        dvd_q <= dvd_n;
        rem_q <= rem_n;
        dm_q  <= dm_n;
        sgn_q <= sgn_n;
        cnt_q <= cnt_n;
        run_q <= run_n;
      end
    end
  end

  always_comb begin
    if (!sgn_q) begin
      quo = (dvd_q > PMAX) ? {1'b0, {(DW-1){1'b1}}} : dvd_q[DW-1:0];
    end else begin
      quo = (dvd_q >= NMAG) ? {1'b1, {(DW-1){1'b0}}} : (~dvd_q[DW-1:0] + 1'b1);
    end
  end

  assign fin = fin_q;

  // R3: the control path never hands the divider a zero divisor
  a_r3_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (den != '0));
  // R7: a new division is only launched when the previous one has ended
  a_r7_div_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

endmodule

// File: rtl/sysbc_cell.sv
module sysbc_cell #(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          phase_sel,
  input  logic [DW-1:0] x_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] c_out,
  output logic [DW-1:0] s_out,
  output logic          err,
  output logic [DW-1:0] r_out
);
  import sysbc_pkg::*;

  localparam int RW = 2 * DW;
  localparam logic signed [DW-1:0] ONE  = DW'(1) << FW;
  localparam logic        [DW-1:0] PMAX = {1'b0, {(DW-1){1'b1}}};

  bc_state_e st_q, st_n;
  bc_phase_e ph_q, ph_n;
  logic signed [DW-1:0] x_q, x_n, r_q, r_n, rn_q, rn_n, c_q, c_n, s_q, s_n;
  logic                 err_q, err_n;

  logic signed [DW-1:0] xs;
  logic signed [RW-1:0] rr, xx;
  logic        [RW-1:0] rad;
  logic                 sq_go, sq_fin;
  logic        [DW-1:0] sq_root, rn_sat;
  logic                 dv_go, dv_fin, dv_neg;
  logic signed [DW-1:0] dv_num, dv_den, dv_quo;

  assign xs     = x_in;
  assign rr     = r_q * r_q;
  assign xx     = xs * xs;
  assign rad    = $unsigned(rr) + $unsigned(xx);
  assign rn_sat = sq_root[DW-1] ? PMAX : sq_root;

  sysbc_isqrt #(.RW(RW)) u_root (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (sq_go),
    .rad  (rad),
    .fin  (sq_fin),
    .root (sq_root)
  );

  sysbc_div #(.DW(DW), .FW(FW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (dv_go),
    .num  (dv_num),
    .den  (dv_den),
    .neg  (dv_neg),
    .fin  (dv_fin),
    .quo  (dv_quo)
  );

  // divider operand selection follows the step that launches it
  always_comb begin
    dv_neg = 1'b0;
    case (st_q)
      ST_IDLE: begin
        dv_num = xs;
        dv_den = r_q;
        dv_neg = 1'b1;
      end
      ST_ROOT: begin
        dv_num = r_q;
        dv_den = rn_sat;
      end
      default: begin
        dv_num = x_q;
        dv_den = rn_q;
      end
    endcase
  end

  always_comb begin
    st_n  = st_q;
    ph_n  = ph_q;
    x_n   = x_q;
    r_n   = r_q;
    rn_n  = rn_q;
    c_n   = c_q;
    s_n   = s_q;
    err_n = err_q;
    sq_go = 1'b0;
    dv_go = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (clr) begin
          r_n = '0;
        end else if (start) begin
          x_n   = xs;
          ph_n  = bc_phase_e'(phase_sel);
          err_n = 1'b0;
          if (phase_sel == PH_ROTATE) begin
            if (r_q == '0 && xs == '0) begin
              c_n  = ONE;
              s_n  = '0;
              st_n = ST_FIN;
            end else begin
              sq_go = 1'b1;
              st_n  = ST_ROOT;
            end
          end else begin
            c_n = '0;
            if (r_q == '0) begin
              s_n   = '0;
              err_n = 1'b1;
              st_n  = ST_FIN;
            end else begin
              dv_go = 1'b1;
              st_n  = ST_QS;
            end
          end
        end
      end
      ST_ROOT: begin
        if (sq_fin) begin
          rn_n  = rn_sat;
          dv_go = 1'b1;
          st_n  = ST_QC;
        end
      end
      ST_QC: begin
        if (dv_fin) begin
          c_n   = dv_quo;
          dv_go = 1'b1;
          st_n  = ST_QS;
        end
      end
      ST_QS: begin
        if (dv_fin) begin
          s_n = dv_quo;
          if (ph_q == PH_ROTATE) r_n = rn_q;
          st_n = ST_FIN;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_ROTATE;
      x_q   <= '0;
      r_q   <= '0;
      rn_q  <= '0;
      c_q   <= '0;
      s_q   <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ph_q  <= ph_n;
      x_q   <= x_n;
      r_q   <= r_n;
      rn_q  <= rn_n;
      c_q   <= c_n;
      s_q   <= s_n;
      err_q <= err_n;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = (st_q == ST_FIN);
  assign c_out = c_q;
  assign s_out = s_q;
  assign err   = err_q;
  assign r_out = r_q;

  // R7: completion strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: a start seen while busy does not disturb the latched entry
  a_r7_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_q));
  // R5: elimination never writes the stored pivot
  a_r5_pivot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_q == PH_ELIM) |=> $stable(r_q));
  // R6: the error flag only reports a zero pivot in elimination
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_q) |-> (ph_q == PH_ELIM && r_q == '0));
  // R2: the stored diagonal never goes negative
  a_r2_r_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    !r_q[DW-1]);
  // R3: the cosine term of a rotation is never negative
  a_r3_c_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ph_q == PH_ROTATE) |-> !c_q[DW-1]);
  // R8: without a clear, an idle cycle keeps the stored value
  a_r8_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> $stable(r_q));
  // R9: results hold while idle and no entry arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(c_q) && $stable(s_q) && $stable(err_q)));

endmodule

// File: tb/sysbc_cell_tb.sv
`timescale 1ns/1ps
module sysbc_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr, start, phase_sel;
  logic [15:0] x_in;
  logic        busy, done, err;
  logic [15:0] c_out, s_out, r_out;

  int n_run  = 0;
  int n_fail = 0;
  int r_m    = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  sysbc_cell u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .phase_sel(phase_sel),
    .x_in(x_in), .busy(busy), .done(done), .c_out(c_out), .s_out(s_out),
    .err(err), .r_out(r_out)
  );

  function automatic int sv(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  // R3 quotient rule
  function automatic int qdiv(input int n, input int d, input bit neg);
    longint an = (n < 0) ? -longint'(n) : longint'(n);
    longint ad = (d < 0) ? -longint'(d) : longint'(d);
    longint m  = (an * 256) / ad;
    bit     ng = (n < 0) ^ (d < 0) ^ neg;
    if (ng) return (m >= 32768) ? -32768 : -int'(m);
    return (m > 32767) ? 32767 : int'(m);
  endfunction

  function automatic int isq(input longint s);
    longint r = longint'($floor($sqrt(real'(s))));
    while (r * r > s) r--;
    while ((r + 1) * (r + 1) <= s) r++;
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(1'b0, "R7 done timeout", 0, 1);
  endtask

  // one operation with model; junk=1 pokes start and clr during busy
  task automatic run_op(input bit ph, input int x, input bit junk);
    int ec, es, ee, er, rn;
    ee = 0;
    er = r_m;
    if (!ph) begin
      if (r_m == 0 && x == 0) begin
        ec = 256; es = 0;                          // R4
      end else begin
        rn = isq(longint'(r_m) * r_m + longint'(x) * x);
        if (rn > 32767) rn = 32767;
        ec = qdiv(r_m, rn, 1'b0);
        es = qdiv(x, rn, 1'b0);
        er = rn;
      end
    end else begin
      ec = 0;
      if (r_m == 0) begin
        es = 0; ee = 1;                            // R6
      end else begin
        es = qdiv(x, r_m, 1'b1);                   // R5
      end
    end
    @(negedge clk);
    start = 1'b1; phase_sel = ph; x_in = x[15:0];
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    if (junk && !done) begin
      start = 1'b1; phase_sel = ~ph; x_in = 16'h1234; clr = 1'b1;
      @(negedge clk);
      start = 1'b0; clr = 1'b0;
    end
    wait_done();
    chk(sv(c_out) == ec, ph ? "R5 c_out" : "R3 c_out", sv(c_out), ec);
    chk(sv(s_out) == es, ph ? "R5 s_out" : "R3 s_out", sv(s_out), es);
    chk(int'(err) == ee, "R6 err", int'(err), ee);
    chk(sv(r_out) == er, ph ? "R5 r kept" : "R2 r update", sv(r_out), er);
    r_m = er;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    r_m = 0;
    chk(sv(r_out) == 0, "R8 clear", sv(r_out), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_run++; n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int vals[12] = '{0, 1, -1, 256, -256, 3, 1000, -5000, 12345, -32768, 32767, 100};
    int hc, hs;
    rst_n = 1'b0; clr = 1'b0; start = 1'b0; phase_sel = 1'b0; x_in = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R1 reset flags", int'(busy) + int'(done) + int'(err), 0);
    chk(c_out == 0 && s_out == 0 && r_out == 0, "R1 reset data", sv(c_out) + sv(s_out) + sv(r_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && r_out == 0, "R1 after release", sv(r_out), 0);

    // R4 zero rotation, then R6 zero pivot
    run_op(1'b0, 0, 1'b0);
    run_op(1'b1, 77, 1'b0);
    // R6 error clears on next completion
    run_op(1'b0, 512, 1'b0);

    // R7 and R8: start and clr during busy are ignored
    run_op(1'b0, -700, 1'b1);
    run_op(1'b1, 300, 1'b1);

    // R9 outputs hold while idle
    hc = sv(c_out); hs = sv(s_out);
    repeat (6) @(negedge clk);
    chk(sv(c_out) == hc, "R9 c hold", sv(c_out), hc);
    chk(sv(s_out) == hs, "R9 s hold", sv(s_out), hs);

    // R8 clr and start together: start dropped
    @(negedge clk);
    clr = 1'b1; start = 1'b1; phase_sel = 1'b0; x_in = 16'd900;
    @(negedge clk);
    clr = 1'b0; start = 1'b0;
    r_m = 0;
    chk(busy == 1'b0, "R8 start dropped", int'(busy), 0);
    chk(sv(r_out) == 0, "R8 cleared", sv(r_out), 0);

    // near-exhaustive sweep over pairs of entries, R2 R3 R5 R6
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        do_clr();
        run_op(1'b0, vals[i], 1'b0);
        run_op(1'b0, vals[j], 1'b0);
        run_op(1'b1, vals[(i + j) % 12], 1'b0);
        run_op(1'b1, vals[(i + 3 * j + 5) % 12], 1'b0);
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule